// File: doc/BRIEF.md
# UART Interrupt and Line Status Logic

This block sits between the receive and transmit FIFOs of a UART and the host-facing register interface. It turns the FIFO fill count, the transmitter empty flags and the per-character error flags into an 8-bit line status word. It also produces a single interrupt request and a 4-bit interrupt identification code. Three enable inputs gate the interrupt sources. The register that holds them is kept by the host interface.

The receive-data interrupt follows the fill level. It is raised while the receive FIFO holds at least the selected trigger level of bytes, and it drops by itself once the fill falls below that level. The error bits are sticky until the host reads the line status word. When all enables are zero the block runs in polled mode. In that mode the status bits keep updating and the interrupt line stays low.

Top module: `uart_int_status`

## Requirements
- R1: While `rst` is high and for the cycle after it, `lsr` is 0x00, `iir` is 4'b0001 and `irq` is 0. This assumes the transmit empty flags are low during reset.
- R2: `lsr[0]` becomes 1 one cycle after `rx_push`. It stays 1 while `rx_count` is non-zero, and it returns to 0 one cycle after a cycle with `rx_count` = 0 and no push.
- R3: The error bits are `lsr[1]` overrun (set by `rx_overrun`), `lsr[2]` parity (`rx_char_err[0]` with a push), `lsr[3]` framing (`rx_char_err[1]`) and `lsr[4]` break (`rx_char_err[2]`). Each bit is sticky and is cleared by `lsr_rd`. A new event in the same cycle as the read wins.
- R4: `lsr[7]` is 1 while the receive FIFO holds at least one character that was pushed with any of `rx_char_err` set. A character leaves this count when it is popped with `rx_pop_err` high. A status read does not clear this bit.
- R5: `lsr[5]` follows `tx_fifo_empty`. `lsr[6]` follows `tx_fifo_empty` AND `tx_shift_empty`. Both lag their inputs by one cycle.
- R6: With `fifo_en` = 1 the receive hit is `rx_count` >= the level picked by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. With `fifo_en` = 0 the hit is `rx_count` != 0.
- R7: The receive-data source (`int_en[0]`) follows the hit. It is raised when the hit appears and drops when it goes away, with no register read needed.
- R8: The line-status source (`int_en[2]`) is pending while any of `lsr[4:1]` is set, so reading `lsr_rd` clears it.
- R9: The transmit-empty source (`int_en[1]`) becomes pending when `tx_fifo_empty` rises, or when `int_en[1]` rises while the transmit FIFO is empty. It is cleared when `tx_fifo_empty` is 0, or by `iir_rd` while `iir` shows 4'b0010. A new set wins over a clear.
- R10: `iir` gives the highest-priority enabled source: 4'b0110 line status, then 4'b0100 receive data, then 4'b0010 transmit empty, and 4'b0001 when none is active. `irq` is 1 exactly when a source is active.
- R11: With `int_en` = 3'b000, `irq` stays 0 and `iir` stays 4'b0001, while `lsr` keeps updating.
- R12: The status bits and pending flags change one clock after their inputs. `irq` and `iir` change one clock after the status they depend on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| int_en | input | 3 | Source enables: [0] receive data, [1] transmit empty, [2] line status |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Current receive FIFO fill |
| rx_push | input | 1 | Character written into receive FIFO this cycle |
| rx_char_err | input | 3 | Errors of the pushed character: [0] parity, [1] framing, [2] break |
| rx_overrun | input | 1 | A character was lost to overrun |
| rx_pop | input | 1 | Character read from receive FIFO this cycle |
| rx_pop_err | input | 1 | The popped character carried an error |
| tx_fifo_empty | input | 1 | Transmit FIFO / holding register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| lsr_rd | input | 1 | Host read of line status |
| iir_rd | input | 1 | Host read of interrupt identification |
| lsr | output | 8 | Line status word |
| iir | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the FIFO signals are self-consistent. `rx_count` matches the history of pushes and pops, it never goes above the depth, a pop happens only when the FIFO is non-empty, and `rx_pop_err` is high only for a character that was pushed with an error. The bench drives these signals from its own queue, which stands in for the FIFO. It pushes only below the depth, pops only from a non-empty queue, and never pushes and pops in the same cycle. The error flag of each pop is taken from the head of the queue, so the errored-character count can never underflow.

// File: rtl/uis_pkg.sv
package uis_pkg;

  typedef enum logic [3:0] {
    IID_NONE    = 4'b0001,
    IID_TXEMPTY = 4'b0010,
    IID_RXDATA  = 4'b0100,
    IID_LSTAT   = 4'b0110
  } iid_e;

  localparam int NUM_ERR = 4;

  function automatic int unsigned trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_bytes = 1;
      2'd1:    trig_bytes = 4;
      2'd2:    trig_bytes = 8;
      default: trig_bytes = 14;
    endcase
  endfunction

endpackage

// File: rtl/uis_rx_status.sv
module uis_rx_status
  import uis_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic [1:0]         trig_sel,
  input  logic [CW-1:0]      rx_count,
  input  logic               rx_push,
  input  logic [2:0]         rx_char_err,
  input  logic               rx_overrun,
  input  logic               rx_pop,
  input  logic               rx_pop_err,
  input  logic               lsr_rd,
  output logic               data_ready,
  output logic [NUM_ERR-1:0] err_flags,
  output logic               fifo_err,
  output logic               rx_hit
);

  logic [NUM_ERR-1:0] err_ev;
  logic [CW-1:0]      bad_cnt;
  logic               char_bad, pop_bad, hit_d;
  logic [31:0]        lvl;

  // event vector in status-bit order: overrun, parity, framing, break
  assign err_ev = {rx_push & rx_char_err[2], rx_push & rx_char_err[1],
                   rx_push & rx_char_err[0], rx_overrun};

  generate
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)            err_flags[i] <= 1'b0;
        else if (err_ev[i]) err_flags[i] <= 1'b1;
        else if (lsr_rd)    err_flags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          data_ready <= 1'b0;
    else if (rx_push) data_ready <= 1'b1;
    else              data_ready <= data_ready & (rx_count != '0);
  end

  assign char_bad = rx_push & (|rx_char_err);
  assign pop_bad  = rx_pop & rx_pop_err;

  always_ff @(posedge clk) begin
    if (rst)                                      bad_cnt <= '0;
    else if (char_bad && !pop_bad)                bad_cnt <= bad_cnt + 1'b1;
    else if (!char_bad && pop_bad && bad_cnt != '0) bad_cnt <= bad_cnt - 1'b1;
  end

  assign fifo_err = (bad_cnt != '0);

  assign lvl   = trig_bytes(trig_sel);
  assign hit_d = fifo_en ? (32'(rx_count) >= lvl) : (rx_count != '0);

  always_ff @(posedge clk) begin
    if (rst) rx_hit <= 1'b0;
    else     rx_hit <= hit_d;
  end

  // R2
  dr_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> data_ready);

  // R2
  dr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_push && rx_count == '0) |=> !data_ready);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !lsr_rd |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R4
  fe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_err && !char_bad) |=> !fifo_err);

endmodule

// File: rtl/uis_tx_status.sv
module uis_tx_status (
  input  logic clk,
  input  logic rst,
  input  logic tx_fifo_empty,
  input  logic tx_shift_empty,
  input  logic en_tx,
  input  logic iir_rd,
  input  logic iir_is_tx,
  output logic thr_empty,
  output logic all_empty,
  output logic tx_pend
);

  logic prev_empty, prev_en, set_p, clr_p;

  assign set_p = tx_fifo_empty & (~prev_empty | (en_tx & ~prev_en));
  assign clr_p = ~tx_fifo_empty | (iir_rd & iir_is_tx);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_empty <= 1'b0;
      prev_en    <= 1'b0;
      thr_empty  <= 1'b0;
      all_empty  <= 1'b0;
      tx_pend    <= 1'b0;
    end else begin
      prev_empty <= tx_fifo_empty;
      prev_en    <= en_tx;
      thr_empty  <= tx_fifo_empty;
      all_empty  <= tx_fifo_empty & tx_shift_empty;
      if (set_p)      tx_pend <= 1'b1;
      else if (clr_p) tx_pend <= 1'b0;
    end
  end

  // R5
  all_implies_thr_chk: assert property (@(posedge clk) disable iff (rst)
    all_empty |-> thr_empty);

  // R9
  pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_fifo_empty |=> !tx_pend);

endmodule

// File: rtl/uis_irq_arb.sv
module uis_irq_arb
  import uis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] int_en,
  input  logic       ls_pend,
  input  logic       rx_hit,
  input  logic       tx_pend,
  output logic       irq,
  output logic [3:0] iir
);

  logic ls_act, rx_act, tx_act;
  iid_e code_d, code_q;

  assign ls_act = int_en[2] & ls_pend;
  assign rx_act = int_en[0] & rx_hit;
  assign tx_act = int_en[1] & tx_pend;

  always_comb begin
    if (ls_act)      code_d = IID_LSTAT;
    else if (rx_act) code_d = IID_RXDATA;
    else if (tx_act) code_d = IID_TXEMPTY;
    else             code_d = IID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= IID_NONE;
      irq    <= 1'b0;
    end else begin
      code_q <= code_d;
      irq    <= ls_act | rx_act | tx_act;
    end
  end

  assign iir = code_q;

  // R11
  polled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (int_en == 3'b000) |=> (!irq && iir == IID_NONE));

  // R10
  ls_first_chk: assert property (@(posedge clk) disable iff (rst)
    (int_en[2] && ls_pend) |=> (irq && iir == IID_LSTAT));

  // R7
  rx_second_chk: assert property (@(posedge clk) disable iff (rst)
    (!(int_en[2] && ls_pend) && int_en[0] && rx_hit) |=> (irq && iir == IID_RXDATA));

endmodule

// File: rtl/uart_int_status.sv
module uart_int_status
  import uis_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic [2:0]    int_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_push,
  input  logic [2:0]    rx_char_err,
  input  logic          rx_overrun,
  input  logic          rx_pop,
  input  logic          rx_pop_err,
  input  logic          tx_fifo_empty,
  input  logic          tx_shift_empty,
  input  logic          lsr_rd,
  input  logic          iir_rd,
  output logic [7:0]    lsr,
  output logic [3:0]    iir,
  output logic          irq
);

  logic               data_ready, fifo_err, rx_hit;
  logic [NUM_ERR-1:0] err_flags;
  logic               thr_empty, all_empty, tx_pend;

  uis_rx_status #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .trig_sel   (trig_sel),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .rx_char_err(rx_char_err),
    .rx_overrun (rx_overrun),
    .rx_pop     (rx_pop),
    .rx_pop_err (rx_pop_err),
    .lsr_rd     (lsr_rd),
    .data_ready (data_ready),
    .err_flags  (err_flags),
    .fifo_err   (fifo_err),
    .rx_hit     (rx_hit)
  );

  uis_tx_status u_tx (
    .clk           (clk),
    .rst           (rst),
    .tx_fifo_empty (tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty),
    .en_tx         (int_en[1]),
    .iir_rd        (iir_rd),
    .iir_is_tx     (iir == IID_TXEMPTY),
    .thr_empty     (thr_empty),
    .all_empty     (all_empty),
    .tx_pend       (tx_pend)
  );

  uis_irq_arb u_arb (
    .clk    (clk),
    .rst    (rst),
    .int_en (int_en),
    .ls_pend(|err_flags),
    .rx_hit (rx_hit),
    .tx_pend(tx_pend),
    .irq    (irq),
    .iir    (iir)
  );

  assign lsr = {fifo_err, all_empty, thr_empty, err_flags, data_ready};

endmodule

// File: tb/uart_int_status_test.sv
module uart_int_status_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0;
  logic [2:0]    int_en = '0;
  logic [1:0]    trig_sel = '0;
  logic [CW-1:0] rx_count = '0;
  logic          rx_push = 1'b0;
  logic [2:0]    rx_char_err = '0;
  logic          rx_overrun = 1'b0;
  logic          rx_pop = 1'b0;
  logic          rx_pop_err = 1'b0;
  logic          tx_fifo_empty = 1'b0;
  logic          tx_shift_empty = 1'b0;
  logic          lsr_rd = 1'b0;
  logic          iir_rd = 1'b0;
  logic [7:0]    lsr;
  logic [3:0]    iir;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit q[$];

  uart_int_status #(.FIFO_DEPTH(DEPTH)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit       m_dr, m_thr, m_all, m_pend, m_pe, m_pen, m_hit, m_irq;
  bit [3:0] m_err;
  int       m_bad;
  bit [3:0] m_iir = 4'b0001;

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dr = 0; m_thr = 0; m_all = 0; m_pend = 0; m_pe = 0; m_pen = 0;
      m_hit = 0; m_irq = 0; m_err = 0; m_bad = 0; m_iir = 4'b0001;
    end else begin
      bit ls, rx, tx, setp;
      bit [3:0] nid;
      bit [3:0] ev;
      ls = int_en[2] && (m_err != 0);
      rx = int_en[0] && m_hit;
      tx = int_en[1] && m_pend;
      nid = ls ? 4'b0110 : rx ? 4'b0100 : tx ? 4'b0010 : 4'b0001;
      setp = tx_fifo_empty && (!m_pe || (int_en[1] && !m_pen));
      if (setp) m_pend = 1;
      else if (!tx_fifo_empty || (iir_rd && m_iir == 4'b0010)) m_pend = 0;
      m_pe = tx_fifo_empty; m_pen = int_en[1];
      m_thr = tx_fifo_empty; m_all = tx_fifo_empty && tx_shift_empty;
      m_iir = nid; m_irq = ls || rx || tx;
      ev = {rx_push & rx_char_err[2], rx_push & rx_char_err[1], rx_push & rx_char_err[0], rx_overrun};
      m_err = (lsr_rd ? 4'b0 : m_err) | ev;
      m_dr = rx_push || (m_dr && rx_count != 0);
      if (rx_push && rx_char_err != 0) m_bad++;
      if (rx_pop && rx_pop_err && m_bad > 0) m_bad--;
      m_hit = fifo_en ? (int'(rx_count) >= lvl_of(trig_sel)) : (rx_count != 0);
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cmp("R2 data ready", lsr[0], m_dr);
    cmp("R3 error bits", lsr[4:1], m_err);
    cmp("R4 fifo error", lsr[7], m_bad != 0);
    cmp("R5 tx empty bits", lsr[6:5], {m_all, m_thr});
    cmp("R10 id code", iir, m_iir);
    cmp("R8 irq", irq, m_irq);
  endtask

  task automatic push(input logic [2:0] e);
    q.push_back(e != 0);
    rx_push = 1; rx_char_err = e; rx_count = CW'(q.size());
    tick();
    rx_push = 0; rx_char_err = 0;
  endtask

  task automatic pop();
    if (q.size() > 0) begin
      rx_pop = 1; rx_pop_err = q[0];
      void'(q.pop_front());
      rx_count = CW'(q.size());
      tick();
      rx_pop = 0; rx_pop_err = 0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) tick();
    // R1 reset values
    cmp("R1 lsr reset", lsr, 0);
    cmp("R1 iir reset", iir, 4'b0001);
    cmp("R1 irq reset", irq, 0);
    rst = 0;
    tick();
    cmp("R1 lsr after reset", lsr, 0);

    // R11 polled mode
    fifo_en = 1; int_en = 3'b000; trig_sel = 0;
    push(3'b000); push(3'b001); push(3'b000);
    tick(); tick();
    cmp("R11 irq polled", irq, 0);
    cmp("R11 iir polled", iir, 4'b0001);
    cmp("R2 ready set", lsr[0], 1);
    cmp("R3 parity set", lsr[2], 1);
    cmp("R4 fifo error set", lsr[7], 1);
    lsr_rd = 1; tick(); lsr_rd = 0;
    cmp("R3 cleared by read", lsr[4:1], 0);
    cmp("R4 kept on read", lsr[7], 1);
    pop(); pop(); pop(); tick(); tick();
    cmp("R2 ready clear", lsr[0], 0);
    cmp("R4 fifo error clear", lsr[7], 0);

    // R6 / R7 / R12 trigger tracking
    trig_sel = 2'd3; int_en = 3'b001;
    repeat (13) push(3'b000);
    tick(); tick();
    cmp("R6 below 14", irq, 0);
    push(3'b000);
    cmp("R12 irq lags hit", irq, 0);
    tick();
    cmp("R7 irq at 14", irq, 1);
    cmp("R7 code rx", iir, 4'b0100);
    pop(); tick();
    cmp("R7 self clear", irq, 0);
    trig_sel = 2'd2; tick(); tick();
    cmp("R6 level 8", irq, 1);
    trig_sel = 2'd3; fifo_en = 0; tick(); tick();
    cmp("R6 non-fifo mode", irq, 1);
    while (q.size() > 0) pop();
    tick(); tick();
    cmp("R6 empty no hit", irq, 0);

    // R10 / R9 / R8 priority and clears
    fifo_en = 1; trig_sel = 0; int_en = 3'b111;
    tx_fifo_empty = 1; tx_shift_empty = 1;
    push(3'b000);
    rx_overrun = 1; tick(); rx_overrun = 0;
    tick();
    cmp("R10 line status first", iir, 4'b0110);
    cmp("R5 both empty", lsr[6:5], 2'b11);
    lsr_rd = 1; tick(); lsr_rd = 0; tick();
    cmp("R8 cleared, rx next", iir, 4'b0100);
    pop(); tick();
    cmp("R9 tx empty pending", iir, 4'b0010);
    iir_rd = 1; tick(); iir_rd = 0; tick();
    cmp("R9 cleared by id read", iir, 4'b0001);
    cmp("R9 irq low", irq, 0);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (n % 97 == 0) int_en = 3'($urandom_range(0, 7));
      if (n % 131 == 0) trig_sel = 2'($urandom_range(0, 3));
      if (n % 211 == 0) fifo_en = 1'($urandom_range(0, 1));
      if (n % 23 == 0) tx_fifo_empty = 1'($urandom_range(0, 1));
      if (n % 17 == 0) tx_shift_empty = 1'($urandom_range(0, 1));
      lsr_rd = ($urandom_range(0, 11) == 0);
      iir_rd = ($urandom_range(0, 7) == 0);
      rx_overrun = ($urandom_range(0, 40) == 0);
      if (r < 5 && q.size() < DEPTH)
        push(($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b000);
      else if (r < 8 && q.size() > 0)
        pop();
      else
        tick();
      lsr_rd = 0; iir_rd = 0; rx_overrun = 0;
    end
    while (q.size() > 0) pop();
    tick(); tick();
    done = 1;
    finish_run();
  end

endmodule